// File: doc/BRIEF.md
# Rectangular Window Pixel Transfer Engine

This block admits one rectangular pixel window at a time into a display pipeline. Configuration inputs give the window's start and end coordinates, a 4-bit pixel format code, a source select and a rotation setting. A start pulse asks the engine to accept the window. The engine checks the setting, looks up the bytes each pixel takes and computes how many data-port writes fill the window. It then counts write strobes until that count is used up. At that point the window is committed and a one-cycle done pulse is raised.

Each committed window is merged into a dirty bounding box, which a display refresher reads. The refresher clears the box with a refresh acknowledge. A write that arrives while no transfer is open tries the setup itself, using whatever configuration is present. The engine also records whether the accepted window takes the rotated line path. Frame-buffer storage, rotation and colour conversion are handled elsewhere.

Top module: `win_xfer_engine`

## Requirements
- R1: After reset, setup_err, done and rotated are 0. The dirty box is empty: both low corners are all ones (2047 with the default width) and both high corners are 0.
- R2: Format code 1 takes 2 bytes per pixel, codes 2 and 3 take 3, codes 5 and 6 take 4, and every other code takes 0. A transfer lasts bytes × (x_end − x_start + 1) × (y_end − y_start + 1) writes.
- R3: Setup is refused when the source select is above 3, when the format gives 0 bytes per pixel, or when either end coordinate is below its start. A refused setup sets setup_err at the next clock edge and leaves any open transfer's count and window untouched. An accepted setup clears setup_err.
- R4: After an accepted start, done stays low through the first len−1 writes. It is high for exactly one cycle, the cycle after the clock edge that samples the last write.
- R5: A write strobe while no transfer is open runs setup from the present configuration and counts as the first write. If that setup is refused, the write is dropped and setup_err is set.
- R6: A start in the same cycle as a write takes priority, and the write is dropped. An accepted start during an open transfer restarts the count with the new window and commits nothing.
- R7: On commit, each low corner becomes the minimum of its old value and the window start. Each high corner becomes the maximum of its old value and start + size (the exclusive end). The box updates at the same edge at which done rises.
- R8: A refresh acknowledge empties the box at the next edge. If a commit falls in the same cycle, the box afterwards holds exactly the committed window.
- R9: rotated takes the value (angle != 0) at each accepted setup and keeps it through refused setups.
- R10: Changes to the configuration inputs during an open transfer do not alter its remaining count or the window it commits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_x_start | input | COORD_W | Window left column |
| cfg_y_start | input | COORD_W | Window top row |
| cfg_x_end | input | COORD_W | Window right column, inclusive |
| cfg_y_end | input | COORD_W | Window bottom row, inclusive |
| cfg_fmt | input | 4 | Pixel format code |
| cfg_src | input | 3 | Data source select |
| cfg_angle | input | 2 | Rotation setting |
| start | input | 1 | Setup request pulse |
| wr_strobe | input | 1 | One data-port write |
| refresh_ack | input | 1 | Dirty box consumed, clear it |
| setup_err | output | 1 | Last setup attempt was refused |
| done | output | 1 | One-cycle window commit pulse |
| rotated | output | 1 | Accepted window uses rotated path |
| dirty_x_lo | output | COORD_W+1 | Dirty box left edge |
| dirty_y_lo | output | COORD_W+1 | Dirty box top edge |
| dirty_x_hi | output | COORD_W+1 | Dirty box right edge, exclusive |
| dirty_y_hi | output | COORD_W+1 | Dirty box bottom edge, exclusive |

## Verification
Every result here comes from a single register stage. setup_err and rotated reflect a start or a write at the edge that samples it. done and the dirty box reflect the last write at the edge that samples it. A refresh acknowledge empties the box at that same edge. The bench changes inputs 1 ns after a rising edge and checks outputs after the next rising edge, so each result is read one cycle after its stimulus. For done, the bench checks every intermediate write as well, so the pulse is shown to appear neither early nor late.

// File: rtl/wxe_pkg.sv
package wxe_pkg;
   localparam int BPP_W   = 3;
   localparam int SRC_MAX = 3;

   // bytes per pixel for each format code; zero marks an unusable code
   function automatic logic [BPP_W-1:0] fmt_bytes(input logic [3:0] code);
      case (code)
         4'd1:       fmt_bytes = 3'd2;
         4'd2, 4'd3: fmt_bytes = 3'd3;
         4'd5, 4'd6: fmt_bytes = 3'd4;
         default:    fmt_bytes = 3'd0;
      endcase
   endfunction
endpackage

// File: rtl/wxe_setup.sv
module wxe_setup #(
   parameter int COORD_W = 10,
   parameter int LEN_W   = 25
) (
   input  logic [COORD_W-1:0] x_start,
   input  logic [COORD_W-1:0] y_start,
   input  logic [COORD_W-1:0] x_end,
   input  logic [COORD_W-1:0] y_end,
   input  logic [3:0]         fmt,
   input  logic [2:0]         src,
   output logic               ok,
   output logic [LEN_W-1:0]   len,
   output logic [COORD_W:0]   ext_x,
   output logic [COORD_W:0]   ext_y
);
   logic [wxe_pkg::BPP_W-1:0] bpp;

   always_comb begin
      bpp   = wxe_pkg::fmt_bytes(fmt);
      ext_x = {1'b0, x_end} - {1'b0, x_start} + 1'b1;
      ext_y = {1'b0, y_end} - {1'b0, y_start} + 1'b1;
      ok    = (int'(src) <= wxe_pkg::SRC_MAX) && (bpp != '0)
              && (x_end >= x_start) && (y_end >= y_start);
      len   = LEN_W'(bpp) * LEN_W'(ext_x) * LEN_W'(ext_y);
   end
endmodule

// File: rtl/wxe_ctrl.sv
module wxe_ctrl #(
   parameter int COORD_W = 10,
   parameter int LEN_W   = 25
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic                    wr,
   input  logic [1:0]              angle,
   input  logic                    setup_ok,
   input  logic [LEN_W-1:0]        setup_len,
   input  logic [COORD_W-1:0]      cfg_x0,
   input  logic [COORD_W-1:0]      cfg_y0,
   input  logic [COORD_W:0]        cfg_ext_x,
   input  logic [COORD_W:0]        cfg_ext_y,
   output logic                    err,
   output logic                    done,
   output logic                    rot,
   output logic                    commit,
   output logic [1:0][COORD_W:0]   cm_lo,
   output logic [1:0][COORD_W:0]   cm_hi
);
   logic [LEN_W-1:0]   rem_q;
   logic [COORD_W-1:0] x0_q, y0_q;
   logic [COORD_W:0]   ex_q, ey_q;
   logic               idle, take;

   always_comb begin
      idle     = (rem_q == '0);
      take     = start | (wr & idle);
      // setup lengths are at least two, so only the counting path commits
      commit   = !start & wr & (rem_q == LEN_W'(1));
      cm_lo[0] = {1'b0, x0_q};
      cm_lo[1] = {1'b0, y0_q};
      cm_hi[0] = {1'b0, x0_q} + ex_q;
      cm_hi[1] = {1'b0, y0_q} + ey_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         x0_q  <= '0;
         y0_q  <= '0;
         ex_q  <= '0;
         ey_q  <= '0;
         err   <= 1'b0;
         done  <= 1'b0;
         rot   <= 1'b0;
      end else begin
         done <= commit;
         if (take) begin
            if (setup_ok) begin
               rem_q <= start ? setup_len : setup_len - LEN_W'(1);
               x0_q  <= cfg_x0;
               y0_q  <= cfg_y0;
               ex_q  <= cfg_ext_x;
               ey_q  <= cfg_ext_y;
               rot   <= |angle;
               err   <= 1'b0;
            end else begin
               err <= 1'b1;
            end
         end else if (wr && !idle) begin
            rem_q <= rem_q - LEN_W'(1);
         end
      end
   end
endmodule

// File: rtl/wxe_dirty_box.sv
module wxe_dirty_box #(
   parameter int COORD_W = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ack,
   input  logic                  commit,
   input  logic [1:0][COORD_W:0] cm_lo,
   input  logic [1:0][COORD_W:0] cm_hi,
   output logic [1:0][COORD_W:0] box_lo,
   output logic [1:0][COORD_W:0] box_hi
);
   localparam logic [COORD_W:0] EMPTY_LO = '1;
   localparam logic [COORD_W:0] EMPTY_HI = '0;

   for (genvar a = 0; a < 2; a++) begin : g_axis
      logic [COORD_W:0] base_lo, base_hi, nxt_lo, nxt_hi;

      always_comb begin
         base_lo = ack ? EMPTY_LO : box_lo[a];
         base_hi = ack ? EMPTY_HI : box_hi[a];
         nxt_lo  = base_lo;
         nxt_hi  = base_hi;
         if (commit) begin
            if (cm_lo[a] < base_lo) nxt_lo = cm_lo[a];
            if (cm_hi[a] > base_hi) nxt_hi = cm_hi[a];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            box_lo[a] <= EMPTY_LO;
            box_hi[a] <= EMPTY_HI;
         end else begin
            box_lo[a] <= nxt_lo;
            box_hi[a] <= nxt_hi;
         end
      end
   end
endmodule

// File: rtl/win_xfer_engine.sv
module win_xfer_engine #(
   parameter int COORD_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [COORD_W-1:0] cfg_x_start,
   input  logic [COORD_W-1:0] cfg_y_start,
   input  logic [COORD_W-1:0] cfg_x_end,
   input  logic [COORD_W-1:0] cfg_y_end,
   input  logic [3:0]         cfg_fmt,
   input  logic [2:0]         cfg_src,
   input  logic [1:0]         cfg_angle,
   input  logic               start,
   input  logic               wr_strobe,
   input  logic               refresh_ack,
   output logic               setup_err,
   output logic               done,
   output logic               rotated,
   output logic [COORD_W:0]   dirty_x_lo,
   output logic [COORD_W:0]   dirty_y_lo,
   output logic [COORD_W:0]   dirty_x_hi,
   output logic [COORD_W:0]   dirty_y_hi
);
   localparam int LEN_W = wxe_pkg::BPP_W + 2 * (COORD_W + 1);

   if (COORD_W < 2 || COORD_W > 14) begin : g_bad_width
      $error("win_xfer_engine: COORD_W out of supported range");
   end

   logic                  s_ok;
   logic [LEN_W-1:0]      s_len;
   logic [COORD_W:0]      s_ext_x, s_ext_y;
   logic                  c_commit;
   logic [1:0][COORD_W:0] c_lo, c_hi, b_lo, b_hi;

   wxe_setup #(.COORD_W(COORD_W), .LEN_W(LEN_W)) u_setup (
      .x_start (cfg_x_start),
      .y_start (cfg_y_start),
      .x_end   (cfg_x_end),
      .y_end   (cfg_y_end),
      .fmt     (cfg_fmt),
      .src     (cfg_src),
      .ok      (s_ok),
      .len     (s_len),
      .ext_x   (s_ext_x),
      .ext_y   (s_ext_y)
   );

   wxe_ctrl #(.COORD_W(COORD_W), .LEN_W(LEN_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .wr        (wr_strobe),
      .angle     (cfg_angle),
      .setup_ok  (s_ok),
      .setup_len (s_len),
      .cfg_x0    (cfg_x_start),
      .cfg_y0    (cfg_y_start),
      .cfg_ext_x (s_ext_x),
      .cfg_ext_y (s_ext_y),
      .err       (setup_err),
      .done      (done),
      .rot       (rotated),
      .commit    (c_commit),
      .cm_lo     (c_lo),
      .cm_hi     (c_hi)
   );

   wxe_dirty_box #(.COORD_W(COORD_W)) u_box (
      .clk    (clk),
      .rst_n  (rst_n),
      .ack    (refresh_ack),
      .commit (c_commit),
      .cm_lo  (c_lo),
      .cm_hi  (c_hi),
      .box_lo (b_lo),
      .box_hi (b_hi)
   );

   assign dirty_x_lo = b_lo[0];
   assign dirty_y_lo = b_lo[1];
   assign dirty_x_hi = b_hi[0];
   assign dirty_y_hi = b_hi[1];
endmodule

// File: rtl/win_xfer_engine_chk.sv
module win_xfer_engine_chk #(
   parameter int COORD_W = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic [2:0]         cfg_src,
   input logic               start,
   input logic               wr_strobe,
   input logic               refresh_ack,
   input logic               setup_err,
   input logic               done,
   input logic [COORD_W:0]   dirty_x_lo,
   input logic [COORD_W:0]   dirty_y_lo,
   input logic [COORD_W:0]   dirty_x_hi,
   input logic [COORD_W:0]   dirty_y_hi
);
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R4
   AST_DONE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(wr_strobe && !start)); // R6
   AST_START_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !done); // R6
   AST_BAD_SRC_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (start && cfg_src > 3'd3) |=> setup_err); // R3
   AST_ACK_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_ack |=> (done || (&dirty_x_lo && &dirty_y_lo
                                && dirty_x_hi == '0 && dirty_y_hi == '0))); // R8
   AST_BOX_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      !refresh_ack |=> (dirty_x_lo <= $past(dirty_x_lo) && dirty_y_lo <= $past(dirty_y_lo)
                        && dirty_x_hi >= $past(dirty_x_hi) && dirty_y_hi >= $past(dirty_y_hi))); // R7
   AST_BOX_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (dirty_x_hi != '0) |-> (dirty_x_lo < dirty_x_hi && dirty_y_lo < dirty_y_hi)); // R7
endmodule

bind win_xfer_engine win_xfer_engine_chk #(.COORD_W(COORD_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_src     (cfg_src),
   .start       (start),
   .wr_strobe   (wr_strobe),
   .refresh_ack (refresh_ack),
   .setup_err   (setup_err),
   .done        (done),
   .dirty_x_lo  (dirty_x_lo),
   .dirty_y_lo  (dirty_y_lo),
   .dirty_x_hi  (dirty_x_hi),
   .dirty_y_hi  (dirty_y_hi)
);

// File: tb/win_xfer_engine_tb.sv
module win_xfer_engine_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] xs = '0, ys = '0, xe = '0, ye = '0;
   logic [3:0] fmt = '0;
   logic [2:0] src = '0;
   logic [1:0] ang = '0;
   logic       start = 1'b0, wr = 1'b0, ack = 1'b0;
   logic       err, done, rot;
   logic [10:0] bxl, byl, bxh, byh;
   int n_vec = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   win_xfer_engine u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_x_start(xs), .cfg_y_start(ys), .cfg_x_end(xe), .cfg_y_end(ye),
      .cfg_fmt(fmt), .cfg_src(src), .cfg_angle(ang),
      .start(start), .wr_strobe(wr), .refresh_ack(ack),
      .setup_err(err), .done(done), .rotated(rot),
      .dirty_x_lo(bxl), .dirty_y_lo(byl), .dirty_x_hi(bxh), .dirty_y_hi(byh)
   );

   typedef struct packed {
      logic [9:0] x0, y0, x1, y1;
      logic [3:0] f;
      logic [2:0] s;
      logic       ok;
      logic [7:0] len;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VEC [NV] = '{
      '{10'd0,    10'd0,    10'd1,    10'd0,    4'd1,  3'd0, 1'b1, 8'd4},
      '{10'd10,   10'd20,   10'd12,   10'd21,   4'd2,  3'd3, 1'b1, 8'd18},
      '{10'd5,    10'd5,    10'd5,    10'd5,    4'd3,  3'd1, 1'b1, 8'd3},
      '{10'd100,  10'd7,    10'd101,  10'd8,    4'd5,  3'd2, 1'b1, 8'd16},
      '{10'd1020, 10'd1000, 10'd1023, 10'd1000, 4'd6,  3'd0, 1'b1, 8'd16},
      '{10'd0,    10'd0,    10'd1,    10'd1,    4'd0,  3'd0, 1'b0, 8'd0},
      '{10'd0,    10'd0,    10'd1,    10'd1,    4'd4,  3'd0, 1'b0, 8'd0},
      '{10'd0,    10'd0,    10'd1,    10'd1,    4'd1,  3'd4, 1'b0, 8'd0},
      '{10'd9,    10'd0,    10'd8,    10'd0,    4'd1,  3'd0, 1'b0, 8'd0},
      '{10'd0,    10'd9,    10'd0,    10'd8,    4'd1,  3'd0, 1'b0, 8'd0},
      '{10'd0,    10'd0,    10'd0,    10'd0,    4'd15, 3'd0, 1'b0, 8'd0}
   };

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input int act, input int exp, input string tag);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic set_cfg(input int x0, input int y0, input int x1, input int y1,
                          input int f, input int s, input int a);
      xs = 10'(x0); ys = 10'(y0); xe = 10'(x1); ye = 10'(y1);
      fmt = 4'(f); src = 3'(s); ang = 2'(a);
   endtask

   task automatic do_start();
      start = 1'b1;
      step();
      start = 1'b0;
   endtask

   // n writes in a row; done must appear only after the last when last_done
   task automatic writes(input int n, input bit last_done, input string tag);
      for (int i = 0; i < n; i++) begin
         wr = 1'b1;
         step();
         chk(int'(done), (i == n - 1 && last_done) ? 1 : 0, tag);
      end
      wr = 1'b0;
   endtask

   task automatic chk_box(input int xl, input int yl, input int xh, input int yh,
                          input string tag);
      chk(int'(bxl), xl, tag);
      chk(int'(byl), yl, tag);
      chk(int'(bxh), xh, tag);
      chk(int'(byh), yh, tag);
   endtask

   task automatic pulse_ack();
      ack = 1'b1;
      step();
      ack = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) step();
      // R1 reset state
      chk(int'(err), 0, "R1 err");
      chk(int'(done), 0, "R1 done");
      chk(int'(rot), 0, "R1 rotated");
      chk_box(2047, 2047, 0, 0, "R1 box empty");
      rst_n = 1'b1;
      step();
      chk_box(2047, 2047, 0, 0, "R1 box after release");

      // table walk: R2 lengths, R3 refusals, R4 done timing, R7 box
      for (int i = 0; i < NV; i++) begin
         pulse_ack();
         chk_box(2047, 2047, 0, 0, "R8 ack empties");
         set_cfg(VEC[i].x0, VEC[i].y0, VEC[i].x1, VEC[i].y1, VEC[i].f, VEC[i].s, 0);
         do_start();
         chk(int'(err), VEC[i].ok ? 0 : 1, "R3 setup verdict");
         if (VEC[i].ok) begin
            writes(int'(VEC[i].len), 1'b1, "R2 R4 count");
            chk_box(VEC[i].x0, VEC[i].y0, VEC[i].x1 + 1, VEC[i].y1 + 1, "R7 box");
            step();
            chk(int'(done), 0, "R4 done one cycle");
         end
      end

      // R5 auto setup from idle, and dropped write on refusal
      pulse_ack();
      set_cfg(3, 4, 4, 4, 1, 0, 0);
      writes(4, 1'b1, "R5 auto setup count");
      chk(int'(err), 0, "R5 err clear");
      set_cfg(3, 4, 4, 4, 1, 5, 0);
      writes(1, 1'b0, "R5 refused write");
      chk(int'(err), 1, "R5 err set");
      set_cfg(3, 4, 4, 4, 1, 0, 0);
      writes(4, 1'b1, "R5 dropped write not counted");

      // R6 start beats a same-cycle write; restart during transfer
      set_cfg(0, 0, 1, 0, 1, 0, 0);
      start = 1'b1; wr = 1'b1;
      step();
      start = 1'b0; wr = 1'b0;
      chk(int'(done), 0, "R6 start priority");
      writes(4, 1'b1, "R6 write dropped under start");
      do_start();
      writes(2, 1'b0, "R6 partial");
      do_start();
      writes(4, 1'b1, "R6 restart");

      // R3 refused start during a transfer keeps its count
      do_start();
      writes(2, 1'b0, "R3 partial");
      set_cfg(0, 0, 1, 0, 0, 0, 0);
      do_start();
      chk(int'(err), 1, "R3 refused mid transfer");
      writes(2, 1'b1, "R3 count kept");

      // R10 config changes while busy ignored
      pulse_ack();
      set_cfg(0, 0, 1, 0, 1, 0, 0);
      do_start();
      set_cfg(50, 50, 60, 60, 6, 0, 0);
      writes(4, 1'b1, "R10 count latched");
      chk_box(0, 0, 2, 1, "R10 window latched");

      // R7 merge of two windows, R8 ack with commit
      pulse_ack();
      set_cfg(200, 300, 203, 301, 1, 0, 0);
      do_start();
      writes(16, 1'b1, "R7 first window");
      set_cfg(10, 400, 11, 400, 1, 0, 0);
      do_start();
      writes(4, 1'b1, "R7 second window");
      chk_box(10, 300, 204, 401, "R7 union");
      set_cfg(7, 8, 8, 8, 1, 0, 0);
      do_start();
      writes(3, 1'b0, "R8 partial");
      wr = 1'b1; ack = 1'b1;
      step();
      wr = 1'b0; ack = 1'b0;
      chk(int'(done), 1, "R8 done with ack");
      chk_box(7, 8, 9, 9, "R8 ack plus commit");

      // R9 rotation flag
      set_cfg(0, 0, 1, 0, 1, 0, 2);
      do_start();
      chk(int'(rot), 1, "R9 angle 2");
      set_cfg(0, 0, 1, 0, 0, 0, 0);
      do_start();
      chk(int'(rot), 1, "R9 kept on refusal");
      set_cfg(0, 0, 1, 0, 1, 0, 0);
      do_start();
      chk(int'(rot), 0, "R9 angle 0");
      writes(4, 1'b1, "R9 finish");

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule